// File: doc/BRIEF.md
# Bit-Arbitrating Byte Transceiver

This block sends and receives bytes on a shared wired-AND serial bus, where logic 0 is dominant. The CPU side writes a byte into a transmit holding register. From there the byte moves into a transmit shift register, which drives one bit per bit period, most significant bit first. The bus level is read back on every bit and compared with the driven bit. A node that drives 1 and reads 0 has lost arbitration, and in general any difference between the driven and the read level ends the transmission. The rule has no notion of where the priority field of a message ends, so it covers priority fields of any length.

A difference on the last bit of a byte is handled differently. The transmitter does not release the bus at once. It drives up to two more recessive (logic 1) bits, and each of them is compared with the bus like a data bit. If the first of these bits already reads back dominant, the second is dropped.

All bus bits, including bits sent by other nodes, are shifted into a receive shift register. Each completed byte is copied into a receive holding register that the CPU reads. A loopback input replaces the bus input with the transmitter's own output. Symbol timing, CRC and message framing are handled elsewhere. A one-cycle `bit_tick` marks each bit period: the driven level is set up before the tick, and the bus is sampled on the tick.

Top module: `bitarb_byte_xcvr`

## Requirements
- R1: After reset, `tx_bus` is 1 (recessive), `tx_active`, `tx_pending`, `arb_lost` and `rx_ready` are 0, and `rx_byte` is 0x00.
- R2: A byte written with `tx_load` while the transmitter is idle starts a transmission on the next clock without a tick. `tx_bus` shows bit 7 first and advances one bit, toward bit 0, on each `bit_tick`, and holds between ticks.
- R3: On a tick where the sampled bus level differs from `tx_bus` on bits 7 down to 1 of a byte, the clock edge of that tick ends the transmission: `tx_active` falls, `tx_bus` returns to 1, and `arb_lost` pulses for exactly one cycle.
- R4: On a tick where the sampled level differs on bit 0 (the eighth bit), the transmitter drives 1 for two more tick periods and ends, with an `arb_lost` pulse, at the tick of the second extra bit.
- R5: If the first extra bit reads back 0, the transmission ends at that tick with an `arb_lost` pulse, and the second extra bit is not driven.
- R6: When the eighth bit completes without a difference and `tx_pending` is 1, the next byte follows with no gap. When `tx_pending` is 0, the transmission ends without `arb_lost`.
- R7: On every tick, the bus level (or the looped-back level) shifts into the receive register, first bit into the MSB. After eight bits, `rx_byte` takes the byte and `rx_ready` pulses for one cycle. The receive bit count restarts when a transmission starts from idle.
- R8: While `loopback` is 1, the receive path and the comparison use `tx_bus` instead of `rx_bus`, so the transmitter never loses arbitration and `rx_bus` has no effect.
- R9: `tx_pending` rises on the edge that captures `tx_load` and falls on the edge at which the shift register takes the byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_tick | input | 1 | One-cycle strobe per bit period |
| tx_load | input | 1 | Writes `tx_data` into the transmit holding register |
| tx_data | input | 8 | Byte to transmit |
| loopback | input | 1 | Routes transmit output to the receive path |
| rx_bus | input | 1 | Level read back from the bus |
| tx_bus | output | 1 | Level driven onto the bus (1 = recessive) |
| tx_active | output | 1 | Transmission in progress |
| tx_pending | output | 1 | Holding register holds an unsent byte |
| arb_lost | output | 1 | One-cycle pulse when transmission ends on a difference |
| rx_byte | output | 8 | Last completed received byte |
| rx_ready | output | 1 | One-cycle pulse when `rx_byte` updates |

## Verification
The checker assumes that `bit_tick` is never high on two consecutive cycles. It also assumes that `loopback` changes only while the transmitter is idle, and that `tx_load` never coincides with the edge at which a byte leaves the holding register. The bench keeps to all three. Every tick is a single-cycle pulse followed by at least one quiet cycle. Loopback is switched only between messages. Second bytes are written between ticks, in the middle of a byte. The bus is modelled as the AND of `tx_bus` and a competitor pattern, so a difference can only be a driven 1 that reads back as 0.

// File: rtl/bitarb_pkg.sv
package bitarb_pkg;
  typedef enum logic [1:0] {
    TX_IDLE = 2'd0,
    TX_DATA = 2'd1,
    TX_EXT1 = 2'd2,
    TX_EXT2 = 2'd3
  } tx_state_e;
endpackage

// File: rtl/bitarb_rst_sync.sv
module bitarb_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic s0_q, s1_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s0_q <= 1'b0;
      s1_q <= 1'b0;
    end else begin
      s0_q <= 1'b1;
      s1_q <= s0_q;
    end
  end

  assign rst_sync_n = s1_q;
endmodule

// File: rtl/bitarb_tx.sv
module bitarb_tx
  import bitarb_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bit_tick,
  input  logic         load,
  input  logic [W-1:0] load_data,
  input  logic         rx_in,
  output logic         tx_bit,
  output logic         active,
  output logic         pending,
  output logic         lost,
  output logic         start
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  tx_state_e    state_q, state_d;
  logic [W-1:0] sh_q, sh_d;
  logic [W-1:0] hold_q;
  logic [CW-1:0] cnt_q, cnt_d;
  logic         pend_q, pend_d;
  logic         lost_q, lost_d;
  logic         take;
  logic         differ;

  assign tx_bit  = (state_q == TX_DATA) ? sh_q[W-1] : 1'b1;
  assign differ  = (rx_in != tx_bit);
  assign active  = (state_q != TX_IDLE);
  assign pending = pend_q;
  assign lost    = lost_q;

  always_comb begin
    state_d = state_q;
    sh_d    = sh_q;
    cnt_d   = cnt_q;
    lost_d  = 1'b0;
    take    = 1'b0;
    start   = 1'b0;
    unique case (state_q)
      TX_IDLE: begin
        if (pend_q && !bit_tick) begin
          state_d = TX_DATA;
          sh_d    = hold_q;
          cnt_d   = '0;
          take    = 1'b1;
          start   = 1'b1;
        end
      end
      TX_DATA: begin
        if (bit_tick) begin
          if (differ) begin
            if (cnt_q == LAST) begin
              state_d = TX_EXT1;
            end else begin
              state_d = TX_IDLE;
              lost_d  = 1'b1;
            end
          end else if (cnt_q == LAST) begin
            if (pend_q) begin
              sh_d  = hold_q;
              cnt_d = '0;
              take  = 1'b1;
            end else begin
              state_d = TX_IDLE;
            end
          end else begin
            sh_d  = {sh_q[W-2:0], 1'b0};
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      TX_EXT1: begin
        if (bit_tick) begin
          if (differ) begin
            state_d = TX_IDLE;
            lost_d  = 1'b1;
          end else begin
            state_d = TX_EXT2;
          end
        end
      end
      TX_EXT2: begin
        if (bit_tick) begin
          state_d = TX_IDLE;
          lost_d  = 1'b1;
        end
      end
      default: state_d = TX_IDLE;
    endcase
  end

  always_comb begin
    pend_d = pend_q;
    if (load)      pend_d = 1'b1;
    else if (take) pend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= TX_IDLE;
      sh_q    <= '0;
      cnt_q   <= '0;
      pend_q  <= 1'b0;
      lost_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      sh_q    <= sh_d;
      cnt_q   <= cnt_d;
      pend_q  <= pend_d;
      lost_q  <= lost_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    hold_q <= '0;
    else if (load) hold_q <= load_data;
  end
endmodule

// File: rtl/bitarb_rx.sv
module bitarb_rx #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bit_tick,
  input  logic         realign,
  input  logic         rx_in,
  output logic [W-1:0] byte_out,
  output logic         ready
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [W-1:0]  sr_q, sr_d, out_q;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          done, rdy_q;

  always_comb begin
    sr_d  = sr_q;
    cnt_d = cnt_q;
    done  = 1'b0;
    if (realign) begin
      cnt_d = '0;
    end else if (bit_tick) begin
      sr_d = {sr_q[W-2:0], rx_in};
      if (cnt_q == LAST) begin
        cnt_d = '0;
        done  = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      cnt_q <= '0;
      rdy_q <= 1'b0;
    end else begin
      sr_q  <= sr_d;
      cnt_q <= cnt_d;
      rdy_q <= done;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    out_q <= '0;
    else if (done) out_q <= sr_d;
  end

  assign byte_out = out_q;
  assign ready    = rdy_q;
endmodule

// File: rtl/bitarb_byte_xcvr.sv
module bitarb_byte_xcvr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bit_tick,
  input  logic         tx_load,
  input  logic [W-1:0] tx_data,
  input  logic         loopback,
  input  logic         rx_bus,
  output logic         tx_bus,
  output logic         tx_active,
  output logic         tx_pending,
  output logic         arb_lost,
  output logic [W-1:0] rx_byte,
  output logic         rx_ready
);
  logic rst_sync_n;
  logic rx_in;
  logic start;

  bitarb_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  // loopback multiplexer: own output replaces the bus level
  assign rx_in = loopback ? tx_bus : rx_bus;

  bitarb_tx #(.W(W)) u_tx (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .bit_tick  (bit_tick),
    .load      (tx_load),
    .load_data (tx_data),
    .rx_in     (rx_in),
    .tx_bit    (tx_bus),
    .active    (tx_active),
    .pending   (tx_pending),
    .lost      (arb_lost),
    .start     (start)
  );

  bitarb_rx #(.W(W)) u_rx (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .bit_tick (bit_tick),
    .realign  (start),
    .rx_in    (rx_in),
    .byte_out (rx_byte),
    .ready    (rx_ready)
  );
endmodule

// File: rtl/bitarb_chk.sv
module bitarb_chk (
  input logic clk,
  input logic rst_n,
  input logic bit_tick,
  input logic loopback,
  input logic tx_bus,
  input logic tx_active,
  input logic arb_lost,
  input logic rx_ready
);
  a_r1_idle_recessive: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_active |-> tx_bus);

  a_r2_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_active && $past(tx_active) && !$past(bit_tick)) |-> $stable(tx_bus));

  a_r3_lost_single: assert property (@(posedge clk) disable iff (!rst_n)
    arb_lost |=> !arb_lost);

  a_r3_lost_idle: assert property (@(posedge clk) disable iff (!rst_n)
    arb_lost |-> !tx_active);

  a_r3_lost_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    arb_lost |-> $past(bit_tick));

  a_r7_ready_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready |-> $past(bit_tick));

  a_r7_ready_single: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready |=> !rx_ready);

  a_r8_loop_no_loss: assert property (@(posedge clk) disable iff (!rst_n)
    loopback |-> !arb_lost);
endmodule

bind bitarb_byte_xcvr bitarb_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bit_tick  (bit_tick),
  .loopback  (loopback),
  .tx_bus    (tx_bus),
  .tx_active (tx_active),
  .arb_lost  (arb_lost),
  .rx_ready  (rx_ready)
);

// File: tb/tb_bitarb_byte_xcvr.sv
module tb_bitarb_byte_xcvr;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_tick = 1'b0;
  logic       tx_load = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic       loopback = 1'b0;
  logic       other = 1'b1;
  logic       rx_bus;
  logic       tx_bus, tx_active, tx_pending, arb_lost, rx_ready;
  logic [7:0] rx_byte;

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 0;
  bit saw_lost, saw_rx;
  logic [7:0] got_rx;

  always #2 clk = ~clk;

  assign rx_bus = tx_bus & other;

  bitarb_byte_xcvr dut (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .tx_load(tx_load),
    .tx_data(tx_data), .loopback(loopback), .rx_bus(rx_bus),
    .tx_bus(tx_bus), .tx_active(tx_active), .tx_pending(tx_pending),
    .arb_lost(arb_lost), .rx_byte(rx_byte), .rx_ready(rx_ready)
  );

  typedef struct packed {
    logic [7:0] mine;
    logic [7:0] comp;
    logic [1:0] ext;
    logic [1:0] nx;
    logic [7:0] exp_rx;
    logic       exp_lost;
  } vec_t;

  localparam vec_t VECS [0:6] = '{
    '{8'hA5, 8'hFF, 2'b11, 2'd0, 8'hA5, 1'b0},
    '{8'hA5, 8'h25, 2'b11, 2'd0, 8'h25, 1'b1},
    '{8'h3C, 8'h3D, 2'b11, 2'd0, 8'h3C, 1'b0},
    '{8'h3D, 8'h3C, 2'b11, 2'd2, 8'h3C, 1'b1},
    '{8'h3D, 8'h3C, 2'b01, 2'd1, 8'h3C, 1'b1},
    '{8'hC3, 8'hCB, 2'b11, 2'd0, 8'hC3, 1'b0},
    '{8'h80, 8'h7F, 2'b11, 2'd0, 8'h7F, 1'b1}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  task automatic do_tick(input logic obit);
    @(negedge clk);
    other = obit;
    bit_tick = 1'b1;
    @(negedge clk);
    bit_tick = 1'b0;
    if (arb_lost) saw_lost = 1;
    if (rx_ready) begin
      saw_rx = 1;
      got_rx = rx_byte;
    end
  endtask

  task automatic write_only(input logic [7:0] b);
    @(negedge clk);
    tx_load = 1'b1;
    tx_data = b;
    @(negedge clk);
    tx_load = 1'b0;
    chk("R9 pending set", {7'd0, tx_pending}, 8'd1);
  endtask

  task automatic load_byte(input logic [7:0] b);
    write_only(b);
    @(negedge clk);
    chk("R2 start", {7'd0, tx_active}, 8'd1);
    chk("R9 pending clear", {7'd0, tx_pending}, 8'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 values during reset and just after release
    chk("R1 tx_bus", {7'd0, tx_bus}, 8'd1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 tx_bus", {7'd0, tx_bus}, 8'd1);
    chk("R1 tx_active", {7'd0, tx_active}, 8'd0);
    chk("R1 tx_pending", {7'd0, tx_pending}, 8'd0);
    chk("R1 pulses", {6'd0, arb_lost, rx_ready}, 8'd0);
    chk("R1 rx_byte", rx_byte, 8'h00);

    // vector table: R2 R3 R4 R5 R7
    for (int v = 0; v < 7; v++) begin
      vec_t t;
      logic gone;
      t = VECS[v];
      saw_lost = 0;
      saw_rx = 0;
      got_rx = 8'h00;
      gone = 0;
      load_byte(t.mine);
      for (int i = 0; i < 8; i++) begin
        logic ex, ob, losing;
        ex = gone ? 1'b1 : t.mine[7-i];
        ob = t.comp[7-i];
        chk("R2 tx bit", {7'd0, tx_bus}, {7'd0, ex});
        losing = !gone && ex && !ob;
        do_tick(ob);
        if (losing) begin
          gone = 1;
          if (i < 7) begin
            chk("R3 stop at once", {7'd0, tx_active}, 8'd0);
            chk("R3 lost pulse", {7'd0, saw_lost}, 8'd1);
          end
        end
      end
      chk("R7 rx ready", {7'd0, saw_rx}, 8'd1);
      chk("R7 rx byte", got_rx, t.exp_rx);
      if (t.nx != 0) chk("R4 no early lost", {7'd0, saw_lost}, 8'd0);
      for (int k = 0; k < int'(t.nx); k++) begin
        chk("R4 extra one", {7'd0, tx_bus}, 8'd1);
        chk("R4 still active", {7'd0, tx_active}, 8'd1);
        do_tick(t.ext[1-k]);
      end
      chk("R3 R4 R5 lost flag", {7'd0, saw_lost}, {7'd0, t.exp_lost});
      chk("R5 R6 idle at end", {7'd0, tx_active}, 8'd0);
      chk("R5 released", {7'd0, tx_bus}, 8'd1);
    end

    // R6 / R9: chained bytes
    saw_lost = 0;
    saw_rx = 0;
    load_byte(8'h12);
    for (int i = 0; i < 8; i++) begin
      chk("R6 byte one bit", {7'd0, tx_bus}, {7'd0, 8'h12 >> (7 - i)} & 8'd1);
      do_tick(1'b1);
      if (i == 2) write_only(8'h34);
    end
    chk("R6 continues", {7'd0, tx_active}, 8'd1);
    chk("R9 taken at boundary", {7'd0, tx_pending}, 8'd0);
    chk("R7 first byte", got_rx, 8'h12);
    for (int i = 0; i < 8; i++) begin
      chk("R6 byte two bit", {7'd0, tx_bus}, {7'd0, 8'h34 >> (7 - i)} & 8'd1);
      do_tick(1'b1);
    end
    chk("R7 second byte", got_rx, 8'h34);
    chk("R6 ends", {7'd0, tx_active}, 8'd0);
    chk("R6 no lost", {7'd0, saw_lost}, 8'd0);

    // R8: loopback with the bus held dominant
    @(negedge clk);
    loopback = 1'b1;
    saw_lost = 0;
    saw_rx = 0;
    load_byte(8'h5A);
    for (int i = 0; i < 8; i++) do_tick(1'b0);
    chk("R8 rx from own output", got_rx, 8'h5A);
    chk("R8 no lost", {7'd0, saw_lost}, 8'd0);
    chk("R8 done", {7'd0, tx_active}, 8'd0);
    @(negedge clk);
    loopback = 1'b0;

    // R7: receive while idle from another node
    saw_rx = 0;
    for (int i = 0; i < 8; i++) do_tick(8'hC9 >> (7 - i));
    chk("R7 idle receive", got_rx, 8'hC9);
    chk("R1 idle tx_bus", {7'd0, tx_bus}, 8'd1);

    // R1: reset in mid-transmission
    load_byte(8'h00);
    do_tick(1'b1);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 reset tx_active", {7'd0, tx_active}, 8'd0);
    chk("R1 reset rx_byte", rx_byte, 8'h00);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 after reset", {7'd0, tx_bus}, 8'd1);

    finish_run();
  end
endmodule